// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block holds a small number of recent virtual-to-physical page translations. Each stored translation also carries a process tag, so entries that belong to different processes can live side by side. A lookup presents a virtual page number (VPN) and a process identifier (PID). When a stored translation matches, the physical page number (PPN) and its permission bits come back combinationally in the same cycle. When nothing matches, a miss request goes out to an external page-table walker. The walker later writes the translation back through the fill port, and the next lookup of that page then hits.

The low-order bits of the VPN choose the set. Only the ways of that set are compared, and a fill can only replace a way of that set. For each set the block keeps a full recency order of its ways. A fill goes into a free way when the set has one. Otherwise it evicts the least recently used way. For context switches and page-table edits, the block offers two maintenance commands: a flush that takes effect in one cycle, and a precise invalidate of one VPN/PID pair.

Top module: `tlb_core`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, including one with VPN 0 and PID 0.
- R2: When `lk_valid` is high and the VPN and PID both match a valid entry in set `lk_vpn[2:0]`, `lk_hit` is high in the same cycle and `lk_ppn`/`lk_perm` carry that entry's stored values.
- R3: An entry whose VPN matches but whose PID differs does not produce a hit.
- R4: `miss_req` is high exactly when `lk_valid` is high and no entry matches. While `lk_valid` is low, both `lk_hit` and `miss_req` are low.
- R5: A fill is written at the next clock edge, so a following lookup of the same VPN/PID hits. If a fill's VPN/PID is already stored in the set, that way is overwritten in place and no second copy is made.
- R6: The set index is the low `log2(SETS)` bits of the VPN, so eight consecutive page numbers land in eight different sets and are all held together.
- R7: A fill into a set that has an invalid way uses the lowest-numbered invalid way and evicts nothing.
- R8: A fill into a full set evicts the way that was used least recently. A hitting lookup and a fill each mark their way as the most recent; a missing lookup changes nothing.
- R9: `flush_all` clears every valid bit at the next edge. In that cycle it overrides any fill or invalidate, and the fill is dropped.
- R10: An invalidate clears only the entry whose VPN and PID both match. When no entry matches, it changes nothing.
- R11: At most one way of a set matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process identifier |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_ppn | output | 20 | Physical page number of the hit |
| lk_perm | output | 3 | Permission bits of the hit |
| miss_req | output | 1 | Request to the walker for a missing translation |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_pid | input | 8 | Process identifier being filled |
| fill_ppn | input | 20 | Physical page number being filled |
| fill_perm | input | 3 | Permission bits being filled |
| inv_valid | input | 1 | Invalidate one entry |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| inv_pid | input | 8 | Process identifier to invalidate |
| flush_all | input | 1 | Clear every entry |

## Verification
The bench targets set 0 in most of its steps. Lookups there pair the same VPN with a different PID, which separates VPN matching from the process tag. A neighbouring VPN lands in another set, which shows the index is taken from the low page bits. A sequence of hits and fills across set 0 has a single correct LRU victim at each fill, and no other replacement order leaves the same set of pages resident. After an invalidate opens a free way while a different way is the LRU one, a fill reveals whether free ways are preferred. A fill of a page that is already stored reveals whether it is overwritten in place or duplicated. Eight consecutive pages, a flush issued together with a fill, and a lookup with `lk_valid` low cover the spread across sets, command priority and the request qualifier.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PID_W  = 8;
    localparam int PPN_W  = 20;
    localparam int PERM_W = 3;

    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;
endpackage

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp
    import tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  tlb_ent_t [WAYS-1:0] ents,
    input  logic     [WAYS-1:0] vld,
    input  logic     [VPN_W-1:0] vpn,
    input  logic     [PID_W-1:0] pid,
    output logic     [WAYS-1:0] match
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = vld[w] && (ents[w].vpn == vpn) && (ents[w].pid == pid);
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int WAY_W = 2,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);
    // age 0 = most recent, WAYS-1 = least recent; each set holds a permutation
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_d, age_q;
    logic [WAYS-1:0] victim_vec;

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_d[touch_set][w] = '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_way = '0;
        victim_vec = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[query_set][w] == WAY_W'(WAYS - 1)) begin
                victim_way    = WAY_W'(w);
                victim_vec[w] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else begin
            age_q <= age_d;
        end
    end

    AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(victim_vec)); // R8

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        logic [WAYS-1:0] seen;
        always_comb begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) seen[age_q[s][w]] = 1'b1;
        end
        AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(seen) == WAYS); // R8
    end
endmodule

// File: rtl/tlb_core.sv
module tlb_core
    import tlb_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              miss_req,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid,
    input  logic              flush_all
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        tlb_ent_t [SETS-1:0][WAYS-1:0] ent;
        logic     [SETS-1:0][WAYS-1:0] vld;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0] lk_set, fill_set, inv_set;
    logic [WAYS-1:0]  lk_match, fill_match, inv_match;
    logic [WAY_W-1:0] lk_way, fill_way, victim_way;
    logic             touch_en;
    logic [IDX_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;

    assign lk_set   = lk_vpn[IDX_W-1:0];
    assign fill_set = fill_vpn[IDX_W-1:0];
    assign inv_set  = inv_vpn[IDX_W-1:0];

    tlb_way_cmp #(.WAYS(WAYS)) u_cmp_lk (
        .ents(s_q.ent[lk_set]), .vld(s_q.vld[lk_set]),
        .vpn(lk_vpn), .pid(lk_pid), .match(lk_match));

    tlb_way_cmp #(.WAYS(WAYS)) u_cmp_fill (
        .ents(s_q.ent[fill_set]), .vld(s_q.vld[fill_set]),
        .vpn(fill_vpn), .pid(fill_pid), .match(fill_match));

    tlb_way_cmp #(.WAYS(WAYS)) u_cmp_inv (
        .ents(s_q.ent[inv_set]), .vld(s_q.vld[inv_set]),
        .vpn(inv_vpn), .pid(inv_pid), .match(inv_match));

    // hit data: OR-select over the (at most one) matching way
    always_comb begin
        lk_ppn  = '0;
        lk_perm = '0;
        lk_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) begin
                lk_ppn  = lk_ppn  | s_q.ent[lk_set][w].ppn;
                lk_perm = lk_perm | s_q.ent[lk_set][w].perm;
                lk_way  = WAY_W'(w);
            end
        end
    end

    assign lk_hit   = lk_valid && (|lk_match);
    assign miss_req = lk_valid && !(|lk_match);

    // fill target: existing copy, else lowest free way, else LRU victim
    always_comb begin
        logic found;
        found    = 1'b0;
        fill_way = victim_way;
        if (|fill_match) begin
            for (int w = 0; w < WAYS; w++)
                if (fill_match[w]) fill_way = WAY_W'(w);
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (!s_q.vld[fill_set][w] && !found) begin
                    fill_way = WAY_W'(w);
                    found    = 1'b1;
                end
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (flush_all) begin
            s_d.vld = '0;
        end else begin
            if (inv_valid) begin
                for (int w = 0; w < WAYS; w++)
                    if (inv_match[w]) s_d.vld[inv_set][w] = 1'b0;
            end
            if (fill_valid) begin
                s_d.ent[fill_set][fill_way] = '{pid: fill_pid, vpn: fill_vpn,
                                                ppn: fill_ppn, perm: fill_perm};
                s_d.vld[fill_set][fill_way] = 1'b1;
            end
        end
    end

    always_comb begin
        touch_en  = 1'b0;
        touch_set = lk_set;
        touch_way = lk_way;
        if (!flush_all && fill_valid) begin
            touch_en  = 1'b1;
            touch_set = fill_set;
            touch_way = fill_way;
        end else if (!flush_all && lk_hit) begin
            touch_en  = 1'b1;
        end
    end

    tlb_lru #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
        .query_set(fill_set), .victim_way(victim_way));

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R11
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (s_q.vld == '0)); // R9
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_all) |=> s_q.vld[$past(fill_set)][$past(fill_way)]); // R5
    AST_INV_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !fill_valid) |=> ($countones(s_q.vld) <= $past($countones(s_q.vld)))); // R10
endmodule

// File: tb/tb_tlb_core.sv
`timescale 1ns/1ps
module tb_tlb_core;
    localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1, OP_INV = 2'd2, OP_FLUSH = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [7:0]  pid;
        logic [19:0] ppn;   // fill data, or expected data on a lookup hit
        logic        hit;   // expected hit for lookups
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VEC [NVEC] = '{
        '{OP_FILL,  20'h00008, 8'd1, 20'hAAAA1, 1'b0, 4'd5},
        '{OP_LOOK,  20'h00008, 8'd1, 20'hAAAA1, 1'b1, 4'd2},  // R2
        '{OP_LOOK,  20'h00008, 8'd2, 20'h00000, 1'b0, 4'd3},  // R3 pid differs
        '{OP_LOOK,  20'h00009, 8'd1, 20'h00000, 1'b0, 4'd6},  // R6 other set
        '{OP_FILL,  20'h00010, 8'd1, 20'hB0001, 1'b0, 4'd8},
        '{OP_FILL,  20'h00018, 8'd1, 20'hB0002, 1'b0, 4'd8},
        '{OP_FILL,  20'h00020, 8'd1, 20'hB0003, 1'b0, 4'd8},
        '{OP_LOOK,  20'h00008, 8'd1, 20'hAAAA1, 1'b1, 4'd8},  // R8 touch
        '{OP_FILL,  20'h00028, 8'd1, 20'hB0004, 1'b0, 4'd8},  // evicts 0x10
        '{OP_LOOK,  20'h00010, 8'd1, 20'h00000, 1'b0, 4'd8},
        '{OP_LOOK,  20'h00008, 8'd1, 20'hAAAA1, 1'b1, 4'd8},
        '{OP_LOOK,  20'h00028, 8'd1, 20'hB0004, 1'b1, 4'd8},
        '{OP_LOOK,  20'h00018, 8'd1, 20'hB0002, 1'b1, 4'd8},
        '{OP_FILL,  20'h00030, 8'd1, 20'hB0005, 1'b0, 4'd8},  // evicts 0x20
        '{OP_LOOK,  20'h00020, 8'd1, 20'h00000, 1'b0, 4'd8},
        '{OP_LOOK,  20'h00030, 8'd1, 20'hB0005, 1'b1, 4'd8},
        '{OP_INV,   20'h00008, 8'd2, 20'h00000, 1'b0, 4'd10}, // R10 no match
        '{OP_LOOK,  20'h00008, 8'd1, 20'hAAAA1, 1'b1, 4'd10},
        '{OP_INV,   20'h00008, 8'd1, 20'h00000, 1'b0, 4'd10},
        '{OP_LOOK,  20'h00008, 8'd1, 20'h00000, 1'b0, 4'd10},
        '{OP_LOOK,  20'h00028, 8'd1, 20'hB0004, 1'b1, 4'd10},
        '{OP_FILL,  20'h00038, 8'd1, 20'hB0006, 1'b0, 4'd7},  // R7 free way, LRU is 0x18
        '{OP_LOOK,  20'h00018, 8'd1, 20'hB0002, 1'b1, 4'd7},
        '{OP_LOOK,  20'h00038, 8'd1, 20'hB0006, 1'b1, 4'd7},
        '{OP_FILL,  20'h00028, 8'd1, 20'hC0000, 1'b0, 4'd5},  // R5 refill in place
        '{OP_LOOK,  20'h00028, 8'd1, 20'hC0000, 1'b1, 4'd5},
        '{OP_LOOK,  20'h00030, 8'd1, 20'hB0005, 1'b1, 4'd5},
        '{OP_FLUSH, 20'h00000, 8'd0, 20'h00000, 1'b0, 4'd9},  // R9
        '{OP_LOOK,  20'h00028, 8'd1, 20'h00000, 1'b0, 4'd9},
        '{OP_LOOK,  20'h00018, 8'd1, 20'h00000, 1'b0, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, fill_valid = 1'b0, inv_valid = 1'b0, flush_all = 1'b0;
    logic [19:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
    logic [7:0]  lk_pid = '0, fill_pid = '0, inv_pid = '0;
    logic [19:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        lk_hit, miss_req;
    logic [19:0] lk_ppn;
    logic [2:0]  lk_perm;
    int          n_checks = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    tlb_core dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .miss_req(miss_req),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_pid(inv_pid),
        .flush_all(flush_all));

    task automatic quiet();
        lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0; flush_all = 1'b0;
    endtask

    // lookup: drive at negedge, sample 1 ns later (combinational result)
    task automatic look(input logic [19:0] vpn, input logic [7:0] pid,
                        input logic exp_hit, input logic [19:0] exp_ppn, input int req);
        logic [22:0] act, exp;
        @(negedge clk);
        quiet();
        lk_valid = 1'b1; lk_vpn = vpn; lk_pid = pid;
        #1;
        n_checks++;
        // perm convention: fills carry ppn[2:0] as permission bits
        act = {lk_hit, miss_req, lk_hit ? {lk_ppn, lk_perm} : 23'h0} [22:0];
        exp = {exp_hit, !exp_hit, exp_hit ? {exp_ppn, exp_ppn[2:0]} : 23'h0} [22:0];
        if (lk_hit !== exp_hit || miss_req !== !exp_hit ||
            (exp_hit && (lk_ppn !== exp_ppn || lk_perm !== exp_ppn[2:0]))) begin
            n_fail++;
            $display("FAIL R%0d vpn=%h pid=%0d: hit=%b miss=%b ppn=%h perm=%h expected hit=%b miss=%b ppn=%h perm=%h",
                     req, vpn, pid, lk_hit, miss_req, lk_ppn, lk_perm,
                     exp_hit, !exp_hit, exp_ppn, exp_ppn[2:0]);
        end
        if (act == exp) begin end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] ppn);
        @(negedge clk);
        quiet();
        fill_valid = 1'b1; fill_vpn = vpn; fill_pid = pid;
        fill_ppn = ppn; fill_perm = ppn[2:0];
    endtask

    task automatic inval(input logic [19:0] vpn, input logic [7:0] pid);
        @(negedge clk);
        quiet();
        inv_valid = 1'b1; inv_vpn = vpn; inv_pid = pid;
    endtask

    task automatic flush();
        @(negedge clk);
        quiet();
        flush_all = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset, even VPN 0 / PID 0 misses
        look(20'h00000, 8'd0, 1'b0, 20'h0, 1);
        look(20'h00008, 8'd1, 1'b0, 20'h0, 1);

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_LOOK:  look(VEC[i].vpn, VEC[i].pid, VEC[i].hit, VEC[i].ppn, int'(VEC[i].req));
                OP_FILL:  fill(VEC[i].vpn, VEC[i].pid, VEC[i].ppn);
                OP_INV:   inval(VEC[i].vpn, VEC[i].pid);
                default:  flush();
            endcase
        end

        // R6: eight consecutive pages occupy eight sets and all stay resident
        for (int i = 0; i < 8; i++) fill(20'h00040 + 20'(i), 8'd3, 20'hD0000 + 20'(i));
        for (int i = 0; i < 8; i++) look(20'h00040 + 20'(i), 8'd3, 1'b1, 20'hD0000 + 20'(i), 6);

        // R9: flush in the same cycle as a fill wins; the fill is dropped
        @(negedge clk);
        quiet();
        flush_all = 1'b1;
        fill_valid = 1'b1; fill_vpn = 20'h00060; fill_pid = 8'd4;
        fill_ppn = 20'hE0000; fill_perm = 3'd0;
        look(20'h00060, 8'd4, 1'b0, 20'h0, 9);
        look(20'h00041, 8'd3, 1'b0, 20'h0, 9);

        // R4: with lk_valid low, a resident page shows neither hit nor miss
        fill(20'h00070, 8'd5, 20'hF0007);
        @(negedge clk);
        quiet();
        lk_vpn = 20'h00070; lk_pid = 8'd5;
        #1;
        n_checks++;
        if (lk_hit !== 1'b0 || miss_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R4 idle lookup: hit=%b miss=%b expected hit=0 miss=0", lk_hit, miss_req);
        end
        look(20'h00070, 8'd5, 1'b1, 20'hF0007, 4);   // R4 then R5 fill visible

        @(negedge clk);
        quiet();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule